// File: doc/BRIEF.md
# Snoop bus relay

This block stands in for the shared bus and main memory that sit between two
cache controllers. Each controller has an outbound port, on which it places
bus requests and replies to snoops, and an inbound port, on which it receives
snoop requests and the results of its own requests. The relay queues each
outbound message, moves it across a single shared transfer slot and delivers it,
possibly rewritten, to the opposite controller's inbound queue.

Bus requests (read, read-exclusive, make-exclusive) cross unchanged, so they
arrive at the other cache as snoops. Replies are rewritten. A reply that carries
the line from a cache becomes a data delivery. A plain completion from a snooper
means that memory owns the line, so it also becomes a data delivery. A
make-exclusive acknowledgement becomes a plain completion. Only one message
crosses per clock. When both sides compete, the side that did not win last time
goes first.

Top module: `snoop_bus_relay`

## Requirements
- R1: Message codes 1 (read), 2 (make-exclusive) and 3 (read-exclusive), accepted on port p, are delivered unchanged on inbound port 1-p.
- R2: Code 4 (cache supplies data), accepted on port p, is delivered on port 1-p as code 7 (data to cache).
- R3: Code 5 (completion), accepted on port p, is delivered on port 1-p as code 7, because memory supplies the line.
- R4: Code 6 (make-exclusive acknowledged), accepted on port p, is delivered on port 1-p as code 5.
- R5: Codes 0 and 7 presented on an outbound port are accepted and discarded. Nothing appears on any inbound port because of them.
- R6: Each queue holds at most two messages (IN_DEPTH = OUT_DEPTH = 2). With the destination stalled, one direction accepts exactly four messages and then drops up_ready for that port.
- R7: At most one message crosses per cycle. When both outbound heads can move, port 0 wins the first contest after reset, and after that the port that did not win the last transfer has priority.
- R8: After reset every queue is empty, both dn_valid bits are 0 and both up_ready bits are 1.
- R9: Each direction delivers messages in the order it accepted them. While dn_valid is high and dn_ready is low, dn_msg holds steady.
- R10: A message accepted at clock edge k on an idle relay appears on dn_valid after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 2 | Outbound message present, one bit per cache |
| up_msg | input | 2x3 | Outbound message code per cache |
| up_ready | output | 2 | Relay can take the outbound message |
| dn_valid | output | 2 | Inbound message present, one bit per cache |
| dn_msg | output | 2x3 | Inbound message code per cache |
| dn_ready | input | 2 | Cache takes the inbound message |

## Verification
The hardest case to reach from the ports is a contest in which both outbound heads are eligible in the same cycle, repeated on the next cycle so that the priority turnover can be seen. The stimulus loads both sides with two messages on consecutive cycles and then watches which inbound port fills after each edge. Back-pressure is reached by holding one dn_ready low while one side injects every cycle, until the egress queue and the ingress queue are both full. Random traffic with random inbound stalls then checks ordering and translation against a scoreboard.

// File: rtl/snoop_relay_pkg.sv
package snoop_relay_pkg;
   localparam int MSG_W = 3;

   typedef enum logic [MSG_W-1:0] {
      MSG_NONE    = 3'd0,
      MSG_RD      = 3'd1,
      MSG_MX      = 3'd2,
      MSG_RX      = 3'd3,
      MSG_DATA_UP = 3'd4,
      MSG_DONE    = 3'd5,
      MSG_MXDONE  = 3'd6,
      MSG_DATA_DN = 3'd7
   } msg_e;
endpackage

// File: rtl/relay_fifo.sv
module relay_fifo #(
   parameter int W     = 3,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;
   logic          push;
   logic          pop;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("relay_fifo: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("relay_fifo: W must be at least 1");
      end
   endgenerate

   assign in_ready  = (cnt != CW'(DEPTH));
   assign out_valid = (cnt != '0);
   assign push      = in_valid && in_ready;
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !pop) begin
         cnt <= cnt + 1'b1;
      end else if (pop && !push) begin
         cnt <= cnt - 1'b1;
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) begin
               slot <= in_data;
            end
         end
         assign out_data = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wr_ptr;
         logic [PW-1:0] rd_ptr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
            end else begin
               if (push) begin
                  wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
               end
               if (pop) begin
                  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (push) begin
               mem[wr_ptr] <= in_data;
            end
         end

         assign out_data = mem[rd_ptr];
      end
   endgenerate

   // R6: occupancy moves by at most one entry per clock
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(cnt) <= int'($past(cnt)) + 1) && (int'(cnt) + 1 >= int'($past(cnt))));

   // R9: a stalled head keeps its value
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/relay_xlate.sv
module relay_xlate
   import snoop_relay_pkg::*;
(
   input  logic [MSG_W-1:0] code_in,
   output logic [MSG_W-1:0] code_out,
   output logic             keep
);
   always_comb begin
      keep     = 1'b1;
      code_out = code_in;
      case (msg_e'(code_in))
         MSG_RD, MSG_MX, MSG_RX: code_out = code_in;
         MSG_DATA_UP:            code_out = MSG_DATA_DN;
         MSG_DONE:               code_out = MSG_DATA_DN;
         MSG_MXDONE:             code_out = MSG_DONE;
         default: begin
            keep     = 1'b0;
            code_out = MSG_NONE;
         end
      endcase
   end
endmodule

// File: rtl/relay_rr2.sv
module relay_rr2 #(
   parameter bit FIRST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   logic prio;

   always_comb begin
      gnt = '0;
      if (req[prio]) begin
         gnt[prio] = 1'b1;
      end else if (req[~prio]) begin
         gnt[~prio] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio <= FIRST;
      end else if (|gnt) begin
         prio <= gnt[0];
      end
   end

   // R7: never more than one winner
   p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt) <= 1);

   // R7: back-to-back contests alternate
   p_rr_alt0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req == 2'b11 && gnt == 2'b01) ##1 (req == 2'b11) |-> gnt == 2'b10);
   p_rr_alt1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req == 2'b11 && gnt == 2'b10) ##1 (req == 2'b11) |-> gnt == 2'b01);
endmodule

// File: rtl/snoop_bus_relay.sv
module snoop_bus_relay
   import snoop_relay_pkg::*;
#(
   parameter int IN_DEPTH   = 2,
   parameter int OUT_DEPTH  = 2,
   parameter bit FIRST_PORT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            up_valid,
   input  logic [1:0][MSG_W-1:0] up_msg,
   output logic [1:0]            up_ready,
   output logic [1:0]            dn_valid,
   output logic [1:0][MSG_W-1:0] dn_msg,
   input  logic [1:0]            dn_ready
);
   localparam int PORTS = 2;

   logic [1:0]            hv;
   logic [1:0]            keep;
   logic [1:0]            elig;
   logic [1:0]            gnt;
   logic [1:0]            eg_in_valid;
   logic [1:0]            eg_in_ready;
   logic [1:0][MSG_W-1:0] hd;
   logic [1:0][MSG_W-1:0] xd;

   generate
      if (IN_DEPTH < 1 || OUT_DEPTH < 1) begin : g_bad_depth
         $error("snoop_bus_relay: queue depths must be at least 1");
      end
   endgenerate

   relay_rr2 #(.FIRST(FIRST_PORT)) i_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (elig),
      .gnt   (gnt)
   );

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         localparam int Q = PORTS - 1 - p;

         relay_fifo #(.W(MSG_W), .DEPTH(IN_DEPTH)) i_ingress (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (up_valid[p]),
            .in_data   (up_msg[p]),
            .in_ready  (up_ready[p]),
            .out_valid (hv[p]),
            .out_data  (hd[p]),
            .out_ready (gnt[p])
         );

         relay_xlate i_xlate (
            .code_in  (hd[p]),
            .code_out (xd[p]),
            .keep     (keep[p])
         );

         assign elig[p]        = hv[p] && (!keep[p] || eg_in_ready[Q]);
         assign eg_in_valid[p] = gnt[Q] && keep[Q];

         relay_fifo #(.W(MSG_W), .DEPTH(OUT_DEPTH)) i_egress (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (eg_in_valid[p]),
            .in_data   (xd[Q]),
            .in_ready  (eg_in_ready[p]),
            .out_valid (dn_valid[p]),
            .out_data  (dn_msg[p]),
            .out_ready (dn_ready[p])
         );

         // R6: a kept message only crosses into a queue with room
         p_dest_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && keep[p]) |-> eg_in_ready[Q]);
      end
   endgenerate

   // R8: reset leaves both inbound ports idle
   p_reset_idle_r8: assert property (@(posedge clk)
      !rst_n |=> dn_valid == 2'b00);
endmodule

// File: tb/test_snoop_bus_relay.sv
module test_snoop_bus_relay;
   import snoop_relay_pkg::*;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [1:0]            up_valid = '0;
   logic [1:0][MSG_W-1:0] up_msg = '0;
   logic [1:0]            up_ready;
   logic [1:0]            dn_valid;
   logic [1:0][MSG_W-1:0] dn_msg;
   logic [1:0]            dn_ready = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int unsigned exp_q0[$];
   int unsigned exp_q1[$];

   always #5 clk = ~clk;

   snoop_bus_relay i_snoop_bus_relay (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_msg(up_msg),
      .up_ready(up_ready), .dn_valid(dn_valid), .dn_msg(dn_msg), .dn_ready(dn_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_keep(input int unsigned c);
      return (c >= 1 && c <= 6);
   endfunction

   function automatic int unsigned exp_code(input int unsigned c);
      if (c == 4 || c == 5) return 7;
      if (c == 6) return 5;
      return c;
   endfunction

   function automatic string tag_of(input int unsigned c);
      if (c == 4) return "R2";
      if (c == 7) return "R2/R3";
      if (c == 5) return "R4";
      return "R1";
   endfunction

   // scoreboard: translation and ordering (R1, R2, R3, R4, R9)
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q0.delete();
         exp_q1.delete();
      end else begin
         for (int p = 0; p < 2; p++) begin
            if (up_valid[p] && up_ready[p] && exp_keep(up_msg[p])) begin
               if (p == 0) exp_q1.push_back(exp_code(up_msg[p]));
               else        exp_q0.push_back(exp_code(up_msg[p]));
            end
         end
         for (int q = 0; q < 2; q++) begin
            if (dn_valid[q] && dn_ready[q]) begin
               int unsigned e;
               if ((q == 0 && exp_q0.size() == 0) || (q == 1 && exp_q1.size() == 0)) begin
                  chk(1'b0, "R5 unexpected delivery", dn_msg[q], 0);
               end else begin
                  e = (q == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                  chk(dn_msg[q] == e, tag_of(e), dn_msg[q], e);
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000) begin
         chk(1'b0, "WATCHDOG", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; up_valid = '0; up_msg = '0; dn_ready = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic after_edge();
      @(posedge clk); #1;
   endtask

   initial begin
      int acc;
      logic [MSG_W-1:0] held;
      void'($urandom(32'h5eed));
      do_reset();

      // R8: reset state
      #1;
      chk(dn_valid == 2'b00, "R8 dn_valid", dn_valid, 0);
      chk(up_ready == 2'b11, "R8 up_ready", up_ready, 3);

      // R10, R4: latency of a lone message
      @(negedge clk);
      up_valid = 2'b10; up_msg[1] = MSG_MXDONE;
      after_edge();
      @(negedge clk); up_valid = '0;
      chk(dn_valid[0] == 1'b0, "R10 early", dn_valid[0], 0);
      after_edge();
      chk(dn_valid[0] == 1'b1, "R10 arrival", dn_valid[0], 1);
      chk(dn_msg[0] == MSG_DONE, "R4 direct", dn_msg[0], MSG_DONE);
      @(negedge clk); dn_ready = 2'b11;
      repeat (3) @(negedge clk);

      // R7: two back-to-back contests
      do_reset();
      @(negedge clk);
      dn_ready = 2'b11;
      up_valid = 2'b11; up_msg[0] = MSG_RD; up_msg[1] = MSG_RX;
      @(negedge clk);
      up_msg[0] = MSG_MX; up_msg[1] = MSG_DATA_UP;
      @(negedge clk);
      up_valid = '0;
      #1; chk(dn_valid == 2'b10, "R7 first win port0", dn_valid, 2);
      after_edge(); chk(dn_valid == 2'b01, "R7 second win port1", dn_valid, 1);
      after_edge(); chk(dn_valid == 2'b10, "R7 third win port0", dn_valid, 2);
      after_edge(); chk(dn_valid == 2'b01, "R7 fourth win port1", dn_valid, 1);
      repeat (3) @(negedge clk);

      // R5: discarded codes
      @(negedge clk);
      up_valid = 2'b01; up_msg[0] = MSG_NONE;
      @(negedge clk); up_msg[0] = MSG_DATA_DN;
      @(negedge clk); up_valid = '0;
      repeat (4) begin
         after_edge();
         chk(dn_valid == 2'b00, "R5 nothing delivered", dn_valid, 0);
      end

      // R6, R9: back-pressure toward port 1
      @(negedge clk);
      dn_ready = 2'b00;
      up_valid = 2'b01;
      acc = 0;
      for (int i = 0; i < 10; i++) begin
         up_msg[0] = MSG_RD + (acc % 3);
         #1;
         if (up_ready[0]) acc++;
         @(negedge clk);
      end
      held = dn_msg[1];
      chk(acc == 4, "R6 accepted count", acc, 4);
      chk(up_ready[0] == 1'b0, "R6 up_ready low", up_ready[0], 0);
      up_valid = '0;
      repeat (3) @(negedge clk);
      chk(dn_valid[1] == 1'b1 && dn_msg[1] == held, "R9 stall hold", dn_msg[1], held);
      dn_ready = 2'b11;
      repeat (8) @(negedge clk);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         up_valid = 2'($urandom);
         up_msg[0] = 3'($urandom);
         up_msg[1] = 3'($urandom);
         dn_ready[0] = ($urandom % 4) != 0;
         dn_ready[1] = ($urandom % 4) != 0;
      end
      @(negedge clk);
      up_valid = '0; dn_ready = 2'b11;
      repeat (20) @(negedge clk);
      chk(exp_q0.size() == 0, "R9 drain port0", exp_q0.size(), 0);
      chk(exp_q1.size() == 0, "R9 drain port1", exp_q1.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule